// File: doc/BRIEF.md
# Configurable Set-Associative Tag Timing Model

This block decides, for a stream of target memory accesses, whether each one would hit or miss in a set-associative cache, and whether a miss would force a dirty line out. It keeps only the tag, valid and dirty metadata of every line and no line data. A cycle-level performance model uses it to charge hit or miss latency and to count cache events.

The arrays are sized once, at build time, for the largest geometry: `2**SET_W` sets, `WAYS` ways, and lines down to `2**OFF_MIN` bytes. At run time three configuration fields select the line size, the number of sets in use and the number of active ways. The set index is produced by shifting the address right by the line-size exponent and masking it to the active set count, so no rebuild is needed. Every configuration write clears the whole cache by sweeping one set per cycle. Lookups are refused while the sweep runs. All active ways of a set are compared in the same cycle. On a miss the victim is the lowest free way, or else a way chosen by a small shift-register sequence.

The reset geometry is 128-byte lines, 64 sets and 4 ways, which gives 32 KB.

Top module: `tagsim_cache`

## Requirements
- R1: After reset the configuration is line exponent 7, set exponent 6 and 4 ways, all lines are invalid, and `busy` stays high for exactly 64 (`2**SET_W`) cycles after the reset edge.
- R2: A lookup is accepted only in a cycle where `req_valid` is 1, `busy` is 0 and `cfg_wr` is 0. An accepted lookup gives `resp_valid`=1 on the next cycle. Any other request gives no response and leaves the cache contents unchanged.
- R3: The set index is `(req_addr >> line_exp) & (2**set_exp - 1)`. The stored and compared tag is all of `req_addr >> line_exp`, so two addresses in the same line always match.
- R4: A lookup hits only if a way whose number is below the active way count holds a valid line with an equal tag in the indexed set. Ways at or above that count never hit and are never allocated.
- R5: A write hit marks the line dirty. A read hit leaves the dirty bit unchanged.
- R6: A miss fills the lowest-numbered active way that is invalid. If every active way is valid, it fills way `L mod ways`, where `L` is the 8-bit replacement register. The filled line becomes valid and is dirty exactly when the access is a write.
- R7: `L` is 8'h01 after reset. It changes only when a miss replaces a valid line, and then becomes `{L[6:0], L[7]^L[5]^L[4]^L[3]}`. A configuration write does not change `L`.
- R8: `resp_wb` is 1 exactly when the response is a miss that replaced a valid dirty line.
- R9: `ev_hit`, `ev_miss` and `ev_wb` are single-cycle pulses in the same cycle as `resp_valid`. `ev_hit` or `ev_miss` is set for every response, and never both.
- R10: `cfg_wr` writes the field chosen by `cfg_sel`. Code 0 sets the line exponent, limited to 4..7. Code 1 sets the set exponent, limited to 0..6. Code 2 sets the way count, limited to 1..4. Code 3 changes no field. Values out of range are clamped to the nearest limit.
- R11: Every `cfg_wr`, whatever the code, invalidates all lines and raises `busy` on the next cycle for 64 cycles. A write during a sweep starts the sweep again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Host clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Field code: 0 line exponent, 1 set exponent, 2 way count, 3 none |
| cfg_data | input | 8 | Value written to the selected field |
| req_valid | input | 1 | Lookup request |
| req_addr | input | ADDR_W (32) | Target byte address |
| req_write | input | 1 | 1 for a store, 0 for a load |
| busy | output | 1 | Invalidation sweep in progress; requests refused |
| resp_valid | output | 1 | Response for the lookup accepted one cycle earlier |
| resp_hit | output | 1 | Lookup hit |
| resp_wb | output | 1 | Miss evicted a dirty line |
| ev_hit | output | 1 | Hit event pulse |
| ev_miss | output | 1 | Miss event pulse |
| ev_wb | output | 1 | Writeback event pulse |

## Verification
Internal state is visible only through later responses. A wrong tag, valid or dirty bit therefore shows up the next time the same set is looked up, as a false hit, a false miss or a wrong `resp_wb`. A fault in the replacement register shows up at the next full-set eviction, when a different line is lost. A behavioural model of the arrays compares every output on every cycle, so the first wrong response is reported in the cycle it appears. A sweep of the wrong length shows at once as a `busy` mismatch. Directed cases cover one-way and two-way sets, tiny set counts, clamped configuration values, and requests made during a sweep.

// File: rtl/tagsim_pkg.sv
package tagsim_pkg;

  // configuration field codes; the decode order is part of the interface
  typedef enum logic [1:0] {
    FLD_LINE = 2'd0,
    FLD_SETS = 2'd1,
    FLD_WAYS = 2'd2,
    FLD_NONE = 2'd3
  } cfg_field_e;

  localparam logic [7:0] RPL_SEED = 8'h01;

  function automatic logic [7:0] rpl_step(input logic [7:0] s);
    return {s[6:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
  endfunction

  function automatic logic [7:0] clamp8(input logic [7:0] v, input int lo, input int hi);
    if (int'(v) < lo) return 8'(lo);
    if (int'(v) > hi) return 8'(hi);
    return v;
  endfunction

endpackage

// File: rtl/tagsim_cfg.sv
module tagsim_cfg import tagsim_pkg::*; #(
  parameter int OFF_MIN  = 4,
  parameter int OFF_MAX  = 7,
  parameter int SET_W    = 6,
  parameter int WAYS     = 4,
  parameter int DEF_LINE = 7,
  parameter int DEF_SETS = 6,
  parameter int DEF_WAYS = 4,
  localparam int OW   = $clog2(OFF_MAX + 1),
  localparam int SW   = $clog2(SET_W + 1),
  localparam int WW   = $clog2(WAYS + 1),
  localparam int SETS = 1 << SET_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_wr,
  input  logic [1:0]       cfg_sel,
  input  logic [7:0]       cfg_data,
  output logic [OW-1:0]    line_exp,
  output logic [SW-1:0]    set_exp,
  output logic [WW-1:0]    way_cnt,
  output logic             sweeping,
  output logic [SET_W-1:0] sweep_set
);

  cfg_field_e fld;
  assign fld = cfg_field_e'(cfg_sel);

  always_ff @(posedge clk) begin
    if (rst) begin
      line_exp  <= OW'(DEF_LINE);
      set_exp   <= SW'(DEF_SETS);
      way_cnt   <= WW'(DEF_WAYS);
      sweeping  <= 1'b1;
      sweep_set <= '0;
    end else if (cfg_wr) begin
      case (fld)
        FLD_LINE: line_exp <= OW'(clamp8(cfg_data, OFF_MIN, OFF_MAX));
        FLD_SETS: set_exp  <= SW'(clamp8(cfg_data, 0, SET_W));
        FLD_WAYS: way_cnt  <= WW'(clamp8(cfg_data, 1, WAYS));
        default:  ;
      endcase
      sweeping  <= 1'b1;
      sweep_set <= '0;
    end else if (sweeping) begin
      sweep_set <= sweep_set + 1'b1;
      if (sweep_set == SET_W'(SETS - 1)) sweeping <= 1'b0;
    end
  end

endmodule

// File: rtl/tagsim_way.sv
module tagsim_way #(
  parameter int SET_W = 6,
  parameter int TAG_W = 28,
  localparam int SETS = 1 << SET_W
) (
  input  logic             clk,
  input  logic             tag_we,
  input  logic [TAG_W-1:0] tag_wdata,
  input  logic             st_we,
  input  logic [SET_W-1:0] st_set,
  input  logic             st_valid,
  input  logic             st_dirty,
  input  logic [SET_W-1:0] rd_set,
  output logic [TAG_W-1:0] rd_tag,
  output logic             rd_valid,
  output logic             rd_dirty
);

  logic [TAG_W-1:0] tag_mem [SETS];
  logic [SETS-1:0]  vld_bits;
  logic [SETS-1:0]  drt_bits;

  // tag store: plain write port, no reset, RAM-inferable
  always_ff @(posedge clk) begin
    if (tag_we) tag_mem[st_set] <= tag_wdata;
  end

  // state bits: cleared by the sweep, never by reset
  always_ff @(posedge clk) begin
    if (st_we) begin
      vld_bits[st_set] <= st_valid;
      drt_bits[st_set] <= st_dirty;
    end
  end

  assign rd_tag   = tag_mem[rd_set];
  assign rd_valid = vld_bits[rd_set];
  assign rd_dirty = drt_bits[rd_set];

endmodule

// File: rtl/tagsim_pick.sv
module tagsim_pick import tagsim_pkg::*; #(
  parameter int WAYS = 4,
  localparam int WW = $clog2(WAYS + 1),
  localparam int WI = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            take,
  input  logic [WAYS-1:0] match_vec,
  input  logic [WAYS-1:0] vld_vec,
  input  logic [WAYS-1:0] drt_vec,
  input  logic [WW-1:0]   way_cnt,
  output logic            hit,
  output logic [WI-1:0]   hit_way,
  output logic [WI-1:0]   victim,
  output logic            vic_valid,
  output logic            vic_dirty
);

  logic [7:0]      rpl_q;
  logic [WAYS-1:0] active;
  logic            has_free;
  logic [WI-1:0]   free_way;
  logic [7:0]      rnd;

  for (genvar w = 0; w < WAYS; w++) begin : g_act
    assign active[w] = way_cnt > WW'(w);
  end

  always_comb begin
    hit      = 1'b0;
    hit_way  = '0;
    has_free = 1'b0;
    free_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (active[w] && vld_vec[w] && match_vec[w]) begin
        hit     = 1'b1;
        hit_way = WI'(w);
      end
      if (active[w] && !vld_vec[w]) begin
        has_free = 1'b1;
        free_way = WI'(w);
      end
    end
  end

  assign rnd       = rpl_q % {{(8 - WW){1'b0}}, way_cnt};
  assign victim    = has_free ? free_way : WI'(rnd);
  assign vic_valid = vld_vec[victim];
  assign vic_dirty = vld_vec[victim] & drt_vec[victim];

  always_ff @(posedge clk) begin
    if (rst)                           rpl_q <= RPL_SEED;
    else if (take && !hit && vic_valid) rpl_q <= rpl_step(rpl_q);
  end

endmodule

// File: rtl/tagsim_cache.sv
module tagsim_cache #(
  parameter int ADDR_W  = 32,
  parameter int OFF_MIN = 4,
  parameter int OFF_MAX = 7,
  parameter int SET_W   = 6,
  parameter int WAYS    = 4,
  localparam int TAG_W  = ADDR_W - OFF_MIN,
  localparam int OW     = $clog2(OFF_MAX + 1),
  localparam int SW     = $clog2(SET_W + 1),
  localparam int WW     = $clog2(WAYS + 1),
  localparam int WI     = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic [1:0]        cfg_sel,
  input  logic [7:0]        cfg_data,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  output logic              busy,
  output logic              resp_valid,
  output logic              resp_hit,
  output logic              resp_wb,
  output logic              ev_hit,
  output logic              ev_miss,
  output logic              ev_wb
);

  logic [OW-1:0]    line_exp;
  logic [SW-1:0]    set_exp;
  logic [WW-1:0]    way_cnt;
  logic             sweeping;
  logic [SET_W-1:0] sweep_set;

  tagsim_cfg #(
    .OFF_MIN(OFF_MIN), .OFF_MAX(OFF_MAX), .SET_W(SET_W), .WAYS(WAYS),
    .DEF_LINE(OFF_MAX), .DEF_SETS(SET_W), .DEF_WAYS(WAYS)
  ) u_cfg (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
    .line_exp(line_exp), .set_exp(set_exp), .way_cnt(way_cnt),
    .sweeping(sweeping), .sweep_set(sweep_set)
  );

  // address split under the live geometry
  logic [TAG_W-1:0] req_tag;
  logic [SET_W-1:0] set_mask;
  logic [SET_W-1:0] req_set;
  logic             take;

  assign req_tag  = TAG_W'(req_addr >> line_exp);
  assign set_mask = SET_W'((32'd1 << set_exp) - 32'd1);
  assign req_set  = req_tag[SET_W-1:0] & set_mask;
  assign take     = req_valid && !sweeping && !cfg_wr;

  // per-way storage
  logic [WAYS-1:0]  vld_vec, drt_vec, match_vec;
  logic [WAYS-1:0]  st_we, tag_we;
  logic [TAG_W-1:0] rd_tag [WAYS];
  logic             st_valid, st_dirty;
  logic [SET_W-1:0] st_set;

  assign st_set = sweeping ? sweep_set : req_set;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    tagsim_way #(.SET_W(SET_W), .TAG_W(TAG_W)) u_way (
      .clk(clk), .tag_we(tag_we[w]), .tag_wdata(req_tag),
      .st_we(st_we[w]), .st_set(st_set), .st_valid(st_valid), .st_dirty(st_dirty),
      .rd_set(req_set), .rd_tag(rd_tag[w]), .rd_valid(vld_vec[w]), .rd_dirty(drt_vec[w])
    );
    assign match_vec[w] = rd_tag[w] == req_tag;
  end

  logic          hit, vic_valid, vic_dirty;
  logic [WI-1:0] hit_way, victim;

  tagsim_pick #(.WAYS(WAYS)) u_pick (
    .clk(clk), .rst(rst), .take(take),
    .match_vec(match_vec), .vld_vec(vld_vec), .drt_vec(drt_vec), .way_cnt(way_cnt),
    .hit(hit), .hit_way(hit_way), .victim(victim),
    .vic_valid(vic_valid), .vic_dirty(vic_dirty)
  );

  // update commands: sweep clears every way, a lookup touches one
  always_comb begin
    st_we    = '0;
    tag_we   = '0;
    st_valid = 1'b0;
    st_dirty = 1'b0;
    if (sweeping) begin
      st_we = '1;
    end else if (take) begin
      st_valid = 1'b1;
      if (hit) begin
        st_we[hit_way] = req_write;
        st_dirty       = 1'b1;
      end else begin
        st_we[victim]  = 1'b1;
        tag_we[victim] = 1'b1;
        st_dirty       = req_write;
      end
    end
  end

  // registered response and event pulses
  logic wb_now;
  assign wb_now = take && !hit && vic_dirty;

  always_ff @(posedge clk) begin
    if (rst) begin
      resp_valid <= 1'b0;
      resp_hit   <= 1'b0;
      resp_wb    <= 1'b0;
      ev_hit     <= 1'b0;
      ev_miss    <= 1'b0;
      ev_wb      <= 1'b0;
    end else begin
      resp_valid <= take;
      resp_hit   <= take && hit;
      resp_wb    <= wb_now;
      ev_hit     <= take && hit;
      ev_miss    <= take && !hit;
      ev_wb      <= wb_now;
    end
  end

  assign busy = sweeping;

endmodule

// File: rtl/tagsim_cache_chk.sv
module tagsim_cache_chk #(
  parameter int SET_W = 6,
  localparam int SETS = 1 << SET_W
) (
  input logic clk,
  input logic rst,
  input logic cfg_wr,
  input logic req_valid,
  input logic busy,
  input logic resp_valid,
  input logic resp_hit,
  input logic resp_wb,
  input logic ev_hit,
  input logic ev_miss,
  input logic ev_wb
);

  int busy_run;
  always_ff @(posedge clk) begin
    if (rst || cfg_wr) busy_run <= 0;
    else if (busy)     busy_run <= busy_run + 1;
  end

  // R2
  resp_from_accept_chk: assert property (@(posedge clk) disable iff (rst)
    resp_valid |-> $past(req_valid && !busy && !cfg_wr));

  // R8
  wb_only_on_miss_chk: assert property (@(posedge clk) disable iff (rst)
    resp_wb |-> (resp_valid && !resp_hit && ev_miss));

  // R9
  hit_miss_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(ev_hit && ev_miss));

  // R9
  event_with_resp_chk: assert property (@(posedge clk) disable iff (rst)
    (ev_hit || ev_miss || ev_wb) |-> resp_valid);

  // R11
  cfg_starts_sweep_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_wr |=> busy);

  // R1
  sweep_length_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (busy_run == SETS));

endmodule

bind tagsim_cache tagsim_cache_chk #(.SET_W(SET_W)) u_chk (
  .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .req_valid(req_valid), .busy(busy),
  .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_wb(resp_wb),
  .ev_hit(ev_hit), .ev_miss(ev_miss), .ev_wb(ev_wb)
);

// File: tb/sim_tagsim_cache.sv
module sim_tagsim_cache;

  localparam int NSETS = 64;
  localparam int NWAYS = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic [7:0]  cfg_data = 8'd0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = 32'd0;
  logic        req_write = 1'b0;
  logic        busy, resp_valid, resp_hit, resp_wb, ev_hit, ev_miss, ev_wb;

  always #10 clk = ~clk;

  tagsim_cache u0 (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
    .req_valid(req_valid), .req_addr(req_addr), .req_write(req_write),
    .busy(busy), .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_wb(resp_wb),
    .ev_hit(ev_hit), .ev_miss(ev_miss), .ev_wb(ev_wb)
  );

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  // ---------------- reference model ----------------
  int          m_line, m_sexp, m_ways, m_left;
  bit          m_busy;
  bit          mv [NSETS][NWAYS];
  bit          md [NSETS][NWAYS];
  int unsigned mt [NSETS][NWAYS];
  bit [7:0]    m_l;
  bit          e_rv, e_hit, e_wb, e_miss;

  function automatic int clampi(int v, int lo, int hi);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction

  task automatic m_clear();
    for (int s = 0; s < NSETS; s++)
      for (int w = 0; w < NWAYS; w++) begin
        mv[s][w] = 0;
        md[s][w] = 0;
      end
  endtask

  task automatic m_edge();
    bit was_busy;
    was_busy = m_busy;
    e_rv = 0; e_hit = 0; e_wb = 0; e_miss = 0;
    if (rst) begin
      m_line = 7; m_sexp = 6; m_ways = 4;
      m_l = 8'h01; m_busy = 1; m_left = NSETS;
      m_clear();
      return;
    end
    if (cfg_wr) begin
      case (cfg_sel)
        2'd0: m_line = clampi(int'(cfg_data), 4, 7);
        2'd1: m_sexp = clampi(int'(cfg_data), 0, 6);
        2'd2: m_ways = clampi(int'(cfg_data), 1, 4);
        default: ;
      endcase
      m_clear();
      m_busy = 1; m_left = NSETS;
    end else if (was_busy) begin
      m_left--;
      m_busy = (m_left != 0);
    end else if (req_valid) begin
      int unsigned tg;
      int s, hw, vw;
      tg = req_addr >> m_line;
      s  = int'(tg & ((32'd1 << m_sexp) - 1));
      hw = -1;
      for (int w = 0; w < m_ways; w++)
        if (hw < 0 && mv[s][w] && mt[s][w] == tg) hw = w;
      e_rv = 1;
      if (hw >= 0) begin
        e_hit = 1;
        if (req_write) md[s][hw] = 1;
      end else begin
        e_miss = 1;
        vw = -1;
        for (int w = 0; w < m_ways; w++)
          if (vw < 0 && !mv[s][w]) vw = w;
        if (vw < 0) begin
          vw   = int'(m_l) % m_ways;
          e_wb = md[s][vw];
          m_l  = {m_l[6:0], m_l[7] ^ m_l[5] ^ m_l[4] ^ m_l[3]};
        end
        mv[s][vw] = 1;
        md[s][vw] = req_write;
        mt[s][vw] = tg;
      end
    end
  endtask

  // ---------------- checking ----------------
  task automatic chk(input bit act, input bit exp, input string req, input string what);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s act=%0d exp=%0d t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic cyc(input bit rv, input logic [31:0] a, input bit wr,
                     input bit cw, input logic [1:0] sel, input logic [7:0] dat,
                     input string tag);
    req_valid = rv; req_addr = a; req_write = wr;
    cfg_wr = cw; cfg_sel = sel; cfg_data = dat;
    @(posedge clk);
    m_edge();
    @(negedge clk);
    chk(busy,       m_busy, "R1/R11", {tag, " busy"});
    chk(resp_valid, e_rv,   "R2",     {tag, " resp_valid"});
    chk(resp_hit,   e_hit,  "R4",     {tag, " resp_hit"});
    chk(resp_wb,    e_wb,   "R8",     {tag, " resp_wb"});
    chk(ev_hit,     e_hit,  "R9",     {tag, " ev_hit"});
    chk(ev_miss,    e_miss, "R9",     {tag, " ev_miss"});
    chk(ev_wb,      e_wb,   "R9",     {tag, " ev_wb"});
  endtask

  task automatic idle(input string tag);
    cyc(0, 32'd0, 0, 0, 2'd0, 8'd0, tag);
  endtask

  task automatic rd(input logic [31:0] a, input string tag);
    cyc(1, a, 0, 0, 2'd0, 8'd0, tag);
  endtask

  task automatic wr(input logic [31:0] a, input string tag);
    cyc(1, a, 1, 0, 2'd0, 8'd0, tag);
  endtask

  task automatic cfg(input logic [1:0] sel, input logic [7:0] dat, input string tag);
    cyc(0, 32'd0, 0, 1, sel, dat, tag);
  endtask

  task automatic settle(input string tag);
    for (int i = 0; i < 200 && m_busy; i++) idle(tag);
  endtask

  // explicit expectations written by hand for directed corner cases
  task automatic expect_now(input bit h, input bit wb, input string req);
    chk(resp_valid, 1'b1, req, "directed resp_valid");
    chk(resp_hit,   h,    req, "directed hit");
    chk(resp_wb,    wb,   req, "directed writeback");
  endtask

  // ---------------- watchdog ----------------
  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 150000 && !done) begin
      done = 1;
      n_chk++; n_err++;
      $display("FAIL R2 watchdog act=running exp=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    // R1: reset state
    cyc(0, 32'd0, 0, 0, 2'd0, 8'd0, "R1 reset");
    cyc(0, 32'd0, 0, 0, 2'd0, 8'd0, "R1 reset");
    chk(busy, 1'b1, "R1", "busy during reset");
    chk(resp_valid, 1'b0, "R1", "no response in reset");
    rst = 1'b0;
    // R2: request refused during the reset sweep
    rd(32'h40, "R2 busy request");
    settle("R1 sweep");
    chk(busy, 1'b0, "R1", "sweep finished");
    rd(32'h40, "R2 after sweep");
    expect_now(1'b0, 1'b0, "R2");          // first lookup after reset misses

    // one way, four sets, 16-byte lines
    cfg(2'd0, 8'd4, "R10 line");
    cfg(2'd1, 8'd2, "R10 sets");
    cfg(2'd2, 8'd1, "R10 ways");
    settle("R11 sweep");
    rd(32'h100, "R5");  expect_now(1'b0, 1'b0, "R5");
    rd(32'h100, "R5");  expect_now(1'b1, 1'b0, "R5");
    rd(32'h140, "R5");  expect_now(1'b0, 1'b0, "R5");   // clean line replaced
    wr(32'h140, "R5");  expect_now(1'b1, 1'b0, "R5");
    rd(32'h100, "R8");  expect_now(1'b0, 1'b1, "R8");   // dirty line replaced
    rd(32'h108, "R3");  expect_now(1'b1, 1'b0, "R3");   // same line
    rd(32'h110, "R3");  expect_now(1'b0, 1'b0, "R3");   // next set
    rd(32'h104, "R3");  expect_now(1'b1, 1'b0, "R3");   // set 0 untouched
    wr(32'h400, "R6");  expect_now(1'b0, 1'b0, "R6");   // write miss fills dirty
    rd(32'h100, "R6");  expect_now(1'b0, 1'b1, "R6");

    // two ways: replacement order
    cfg(2'd2, 8'd2, "R4 ways");
    settle("R11 sweep");
    rd(32'h000, "R6"); rd(32'h040, "R6");
    rd(32'h000, "R4"); expect_now(1'b1, 1'b0, "R4");
    rd(32'h040, "R4"); expect_now(1'b1, 1'b0, "R4");
    rd(32'h080, "R7");   // L=01 -> way 1 evicted
    rd(32'h000, "R7"); expect_now(1'b1, 1'b0, "R7");
    rd(32'h040, "R7"); expect_now(1'b0, 1'b0, "R7");
    for (int i = 0; i < 24; i++) rd(32'h40 * (i % 5), "R7 churn");

    // R10: clamping and the no-op code
    cfg(2'd2, 8'd0,   "R10 ways0");
    settle("R10 sweep");
    rd(32'h0, "R10"); rd(32'h40, "R10");
    rd(32'h0, "R10"); expect_now(1'b0, 1'b0, "R10");   // only one way
    cfg(2'd0, 8'd15,  "R10 line15");
    cfg(2'd1, 8'd9,   "R10 sets9");
    cfg(2'd2, 8'd200, "R10 ways200");
    cfg(2'd3, 8'd1,   "R10 noop");
    settle("R10 sweep");
    for (int i = 0; i < 5; i++) rd(32'h2000 * i, "R10 fill");
    rd(32'h0, "R10 geometry");
    rd(32'h80, "R10 line size"); expect_now(1'b0, 1'b0, "R10");
    rd(32'h7F, "R10 line size"); expect_now(1'b1, 1'b0, "R10");

    // R11: write during a sweep restarts it; invalidation visible
    wr(32'h300, "R11 prime");
    cfg(2'd3, 8'd0, "R11 first");
    for (int i = 0; i < 10; i++) rd(32'h300, "R2 refused");
    cfg(2'd3, 8'd0, "R11 restart");
    cyc(1, 32'h300, 1, 1, 2'd3, 8'd0, "R2 with cfg_wr");
    settle("R11 sweep");
    rd(32'h300, "R11"); expect_now(1'b0, 1'b0, "R11");

    // randomized traffic under changing geometry
    for (int i = 0; i < 6000; i++) begin
      int r;
      r = int'($urandom % 1000);
      if (r < 3) cfg(2'($urandom % 4), 8'($urandom % 9), "RND cfg");
      else if (r < 800)
        cyc(1, ((32'($urandom) % 4) << 14) | (32'($urandom) % 2048),
            bit'($urandom % 2), 0, 2'd0, 8'd0, "RND");
      else idle("RND idle");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule